// File: doc/BRIEF.md
# Voice Interrupt Priority Arbiter

This block holds the pending interrupt requests of up to 32 synthesis voices in two vectors. One vector records wavetable loop-end events and the other records volume-ramp-end events. Voice logic raises a one-cycle set pulse on the bit of the voice that needs attention. The block keeps the bit pending until the host services it.

The host services requests one at a time. It writes the service code to the function-select register. On each trigger the arbiter takes one request from the wavetable vector if that vector holds anything. Otherwise it takes one from the ramp vector. It clears the chosen pending bit and pulses a one-hot strobe to the voice, which uses it to drop the flag in its own control byte. It also latches a result byte that names the voice and the source. Two summary bits in a global status byte show whether each vector is non-empty. The interrupt line is high whenever that status is non-zero.

A write to the reset register with bit 0 low clears both vectors and the status.

Top module: `voice_irq_arbiter`

## Requirements
- R1: A service happens only in a cycle where `fsel_we_i` is high and `fsel_data_i` is 8'h8F. A function-select write of any other value leaves the result and both vectors unchanged.
- R2: If any wavetable bit is pending, the trigger looks only at the wavetable vector. The ramp vector is examined only when the wavetable vector is entirely zero.
- R3: Within the chosen vector, the pending voice with the lowest index is serviced.
- R4: Servicing wavetable voice v latches result 8'h60 | v. Servicing ramp voice v latches result 8'h80 | v.
- R5: A trigger with both vectors zero latches result 8'hE8. The result is also 8'hE8 after `rst_ni`.
- R6: In the cycle after a service, the serviced pending bit is clear. In that same cycle the matching strobe output (`wt_ctrl_clr_o` or `vr_ctrl_clr_o`) carries a one-hot pulse at that voice's index, and at most one of the two strobes is non-zero.
- R7: Only voices 0 to 30 are scanned, so voice 31 is never serviced. If the only pending bit of the vector chosen by R2 is voice 31, a trigger leaves the result and both vectors unchanged.
- R8: Status bit 5 is 1 exactly when the wavetable vector is non-empty, and bit 6 is 1 exactly when the ramp vector is non-empty. All other status bits are 0. `irq_o` is high exactly when the status is non-zero.
- R9: A reset-register write with data bit 0 = 0 clears both vectors and the status. It overrides a set pulse and a trigger in the same cycle, and the result holds. A write with bit 0 = 1 has no effect.
- R10: If a set pulse and a service clear hit the same voice in one cycle, that bit stays pending.
- R11: The result keeps its value in every cycle without a trigger.
- R12: Every output changes only on the rising edge after the input that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wt_set_i | input | 32 | Per-voice wavetable loop-end set pulses |
| vr_set_i | input | 32 | Per-voice volume-ramp-end set pulses |
| fsel_we_i | input | 1 | Function-select register write strobe |
| fsel_data_i | input | 8 | Function-select write data |
| srst_we_i | input | 1 | Reset register write strobe |
| srst_data_i | input | 8 | Reset register write data; bit 0 low requests a clear |
| result_o | output | 8 | Latched service result byte |
| wt_pend_o | output | 32 | Pending wavetable vector |
| vr_pend_o | output | 32 | Pending ramp vector |
| wt_ctrl_clr_o | output | 32 | One-hot strobe: clear bit 7 of the voice's wave control byte |
| vr_ctrl_clr_o | output | 32 | One-hot strobe: clear bit 7 of the voice's ramp control byte |
| gstat_o | output | 8 | Global interrupt status (bits 5 and 6 driven here) |
| irq_o | output | 1 | Interrupt request line |

## Verification
The bench tests the case where a ramp request waits behind a wavetable request. A design that ordered the sources wrongly would return an 8'h8x result while a wavetable bit is still pending. It also fills voice 31 alone. A scan that covered all 32 bits would service it, and a scan that fell through to the ramp vector would service a ramp voice instead of holding.

A set pulse on the voice that is being serviced catches designs where the clear wins, because those lose the new request. A clear write that coincides with a set pulse catches designs where the set survives the clear. A long random phase with sparse pulses compares the result, both vectors, both strobes and the status against a behavioural model on every clock. That exposes a stale summary bit or an interrupt line that stays high after the last request is drained.

// File: rtl/voice_irq_pkg.sv
package voice_irq_pkg;
  localparam logic [7:0] SVC_CODE   = 8'h8F;
  localparam logic [7:0] RES_NONE   = 8'hE8;
  localparam logic [7:0] RES_WT_TAG = 8'h60;
  localparam logic [7:0] RES_VR_TAG = 8'h80;
  localparam int unsigned STAT_WT_BIT = 5;
  localparam int unsigned STAT_VR_BIT = 6;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_WT    = 2'd1,
    SRC_VR    = 2'd2,
    SRC_STALL = 2'd3
  } svc_src_e;
endpackage

// File: rtl/voice_prio_enc.sv
module voice_prio_enc #(
  parameter int unsigned W    = 32,
  parameter int unsigned SCAN = 31,
  localparam int unsigned IW  = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins; bits at or above SCAN are invisible
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = int'(SCAN) - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/voice_pend_vec.sv
module voice_pend_vec #(
  parameter int unsigned NV  = 32,
  localparam int unsigned IW = $clog2(NV)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [NV-1:0] set_i,
  input  logic          clr_i,
  input  logic [IW-1:0] clr_idx_i,
  output logic [NV-1:0] pend_o,
  output logic [NV-1:0] pend_nxt_o
);
  logic [NV-1:0] pend_q;
  logic [NV-1:0] clr_mask;

  assign clr_mask   = clr_i ? (NV'(1) << clr_idx_i) : '0;
  // set after clear: a same-cycle set survives
  assign pend_nxt_o = flush_i ? '0 : ((pend_q & ~clr_mask) | set_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_nxt_o;
  end

  assign pend_o = pend_q;

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> ((pend_o & $past(set_i)) == $past(set_i)));

  p_flush_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (pend_o == '0));
endmodule

// File: rtl/voice_irq_arbiter.sv
module voice_irq_arbiter
  import voice_irq_pkg::*;
#(
  parameter int unsigned NV   = 32,
  parameter int unsigned SCAN = 31,
  localparam int unsigned IW  = $clog2(NV)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NV-1:0] wt_set_i,
  input  logic [NV-1:0] vr_set_i,
  input  logic          fsel_we_i,
  input  logic [7:0]    fsel_data_i,
  input  logic          srst_we_i,
  input  logic [7:0]    srst_data_i,
  output logic [7:0]    result_o,
  output logic [NV-1:0] wt_pend_o,
  output logic [NV-1:0] vr_pend_o,
  output logic [NV-1:0] wt_ctrl_clr_o,
  output logic [NV-1:0] vr_ctrl_clr_o,
  output logic [7:0]    gstat_o,
  output logic          irq_o
);
  logic          flush, svc;
  logic          wt_hit, vr_hit;
  logic [IW-1:0] wt_idx, vr_idx;
  logic          wt_clr, vr_clr;
  logic [NV-1:0] wt_nxt, vr_nxt;
  svc_src_e      src;
  logic [7:0]    result_q, gstat_q;
  logic [NV-1:0] wt_stb_q, vr_stb_q;

  assign flush = srst_we_i && !srst_data_i[0];
  assign svc   = fsel_we_i && (fsel_data_i == SVC_CODE) && !flush;

  voice_prio_enc #(.W(NV), .SCAN(SCAN)) u_wt_enc (
    .req_i(wt_pend_o), .hit_o(wt_hit), .idx_o(wt_idx));
  voice_prio_enc #(.W(NV), .SCAN(SCAN)) u_vr_enc (
    .req_i(vr_pend_o), .hit_o(vr_hit), .idx_o(vr_idx));

  // a non-empty wave vector blocks the ramp vector even if nothing in it is scannable
  always_comb begin
    if (|wt_pend_o)      src = wt_hit ? SRC_WT : SRC_STALL;
    else if (|vr_pend_o) src = vr_hit ? SRC_VR : SRC_STALL;
    else                 src = SRC_NONE;
  end

  assign wt_clr = svc && (src == SRC_WT);
  assign vr_clr = svc && (src == SRC_VR);

  voice_pend_vec #(.NV(NV)) u_wt_vec (
    .clk_i, .rst_ni, .flush_i(flush), .set_i(wt_set_i),
    .clr_i(wt_clr), .clr_idx_i(wt_idx), .pend_o(wt_pend_o), .pend_nxt_o(wt_nxt));
  voice_pend_vec #(.NV(NV)) u_vr_vec (
    .clk_i, .rst_ni, .flush_i(flush), .set_i(vr_set_i),
    .clr_i(vr_clr), .clr_idx_i(vr_idx), .pend_o(vr_pend_o), .pend_nxt_o(vr_nxt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= RES_NONE;
    end else if (svc) begin
      unique case (src)
        SRC_WT:   result_q <= RES_WT_TAG | 8'(wt_idx);
        SRC_VR:   result_q <= RES_VR_TAG | 8'(vr_idx);
        SRC_NONE: result_q <= RES_NONE;
        default:  result_q <= result_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wt_stb_q <= '0;
      vr_stb_q <= '0;
      gstat_q  <= '0;
    end else begin
      wt_stb_q <= wt_clr ? (NV'(1) << wt_idx) : '0;
      vr_stb_q <= vr_clr ? (NV'(1) << vr_idx) : '0;
      gstat_q  <= '0;
      gstat_q[STAT_WT_BIT] <= |wt_nxt;
      gstat_q[STAT_VR_BIT] <= |vr_nxt;
    end
  end

  assign result_o      = result_q;
  assign wt_ctrl_clr_o = wt_stb_q;
  assign vr_ctrl_clr_o = vr_stb_q;
  assign gstat_o       = gstat_q;
  assign irq_o         = |gstat_q;

  p_strobe_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wt_ctrl_clr_o) && $onehot0(vr_ctrl_clr_o) &&
    !((|wt_ctrl_clr_o) && (|vr_ctrl_clr_o)));

  p_strobe_cleared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wt_ctrl_clr_o) |-> ((wt_ctrl_clr_o & wt_pend_o & ~$past(wt_set_i)) == '0));

  p_stat_tracks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gstat_o[STAT_WT_BIT] == (|wt_pend_o)) && (gstat_o[STAT_VR_BIT] == (|vr_pend_o)));

  p_empty_result_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc && (wt_pend_o == '0) && (vr_pend_o == '0)) |=> (result_o == RES_NONE));

  p_wt_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc && wt_hit) |=> (result_o[7:5] == 3'b011));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !svc |=> $stable(result_o));
endmodule

// File: tb/voice_irq_arbiter_tb.sv
module voice_irq_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wset = '0, vset = '0;
  logic        fwe = 1'b0, rwe = 1'b0;
  logic [7:0]  fdat = '0, rdat = '0;
  logic [7:0]  result, gstat;
  logic [31:0] wpend, vpend, wclr, vclr;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  voice_irq_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wt_set_i(wset), .vr_set_i(vset),
    .fsel_we_i(fwe), .fsel_data_i(fdat), .srst_we_i(rwe), .srst_data_i(rdat),
    .result_o(result), .wt_pend_o(wpend), .vr_pend_o(vpend),
    .wt_ctrl_clr_o(wclr), .vr_ctrl_clr_o(vclr), .gstat_o(gstat), .irq_o(irq));

  // behavioural reference model
  logic [31:0] m_wt, m_vr, m_wclr, m_vclr;
  logic [7:0]  m_res, m_stat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wt = '0; m_vr = '0; m_wclr = '0; m_vclr = '0; m_res = 8'hE8; m_stat = '0;
    end else begin
      int found;
      m_wclr = '0; m_vclr = '0;
      if (rwe && !rdat[0]) begin
        m_wt = '0; m_vr = '0;
      end else begin
        if (fwe && fdat == 8'h8F) begin
          found = -1;
          if (m_wt != 0) begin
            for (int v = 0; v < 31; v++) if (m_wt[v] && found < 0) found = v;
            if (found >= 0) begin
              m_wt[found] = 1'b0; m_wclr[found] = 1'b1; m_res = 8'h60 | 8'(found);
            end
          end else if (m_vr != 0) begin
            for (int v = 0; v < 31; v++) if (m_vr[v] && found < 0) found = v;
            if (found >= 0) begin
              m_vr[found] = 1'b0; m_vclr[found] = 1'b1; m_res = 8'h80 | 8'(found);
            end
          end else begin
            m_res = 8'hE8;
          end
        end
        m_wt = m_wt | wset;
        m_vr = m_vr | vset;
      end
      m_stat = {1'b0, |m_vr, |m_wt, 5'b0};
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4", "model result", 32'(result), 32'(m_res));
      chk("R3", "model wave vector", wpend, m_wt);
      chk("R2", "model ramp vector", vpend, m_vr);
      chk("R6", "model wave strobe", wclr, m_wclr);
      chk("R6", "model ramp strobe", vclr, m_vclr);
      chk("R8", "model status", 32'(gstat), 32'(m_stat));
      chk("R8", "model irq", 32'(irq), 32'(m_stat != 0));
    end
  end

  task automatic step(logic [31:0] ws, logic [31:0] vs, logic fw, logic [7:0] fd,
                      logic rw, logic [7:0] rd);
    @(negedge clk);
    wset = ws; vset = vs; fwe = fw; fdat = fd; rwe = rw; rdat = rd;
    @(negedge clk);
    wset = '0; vset = '0; fwe = 1'b0; rwe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5", "reset result", 32'(result), 32'hE8);
    chk("R8", "reset irq", 32'(irq), 32'h0);

    step(32'h0000_0208, 32'h0000_0004, 1'b0, 8'h00, 1'b0, 8'h00);
    chk("R8", "status both", 32'(gstat), 32'h60);
    chk("R12", "wave pending", wpend, 32'h0000_0208);

    step('0, '0, 1'b1, 8'h8F, 1'b0, 8'h00);
    chk("R1", "lowest wave", 32'(result), 32'h63);
    chk("R6", "cleared bit", wpend, 32'h0000_0200);
    chk("R6", "strobe", wclr, 32'h0000_0008);

    step('0, '0, 1'b1, 8'h8E, 1'b0, 8'h00);
    chk("R11", "hold on other code", 32'(result), 32'h63);
    chk("R1", "no service", wpend, 32'h0000_0200);

    step('0, '0, 1'b1, 8'h8F, 1'b0, 8'h00);
    chk("R3", "second wave", 32'(result), 32'h69);
    chk("R8", "wave empty status", 32'(gstat), 32'h40);

    step('0, '0, 1'b1, 8'h8F, 1'b0, 8'h00);
    chk("R2", "ramp after wave", 32'(result), 32'h82);
    chk("R8", "irq drops", 32'(irq), 32'h0);

    step('0, '0, 1'b1, 8'h8F, 1'b0, 8'h00);
    chk("R5", "none pending", 32'(result), 32'hE8);

    step(32'h8000_0000, 32'h0000_0002, 1'b0, 8'h00, 1'b0, 8'h00);
    step('0, '0, 1'b1, 8'h8F, 1'b0, 8'h00);
    chk("R7", "voice 31 stall result", 32'(result), 32'hE8);
    chk("R7", "voice 31 kept", wpend, 32'h8000_0000);
    chk("R7", "ramp untouched", vpend, 32'h0000_0002);

    step('0, '0, 1'b0, 8'h00, 1'b1, 8'h01);
    chk("R9", "bit0 high no clear", vpend, 32'h0000_0002);
    step(32'h0000_0010, '0, 1'b1, 8'h8F, 1'b1, 8'h00);
    chk("R9", "clear wave", wpend, 32'h0);
    chk("R9", "clear ramp", vpend, 32'h0);
    chk("R9", "clear status", 32'(gstat), 32'h0);
    chk("R9", "result holds", 32'(result), 32'hE8);

    step(32'h0000_0020, '0, 1'b0, 8'h00, 1'b0, 8'h00);
    step(32'h0000_0020, '0, 1'b1, 8'h8F, 1'b0, 8'h00);
    chk("R10", "result", 32'(result), 32'h65);
    chk("R10", "set wins", wpend, 32'h0000_0020);
    chk("R10", "strobe", wclr, 32'h0000_0020);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wset = ($urandom % 6 == 0) ? (32'h1 << ($urandom % 32)) : '0;
      vset = ($urandom % 6 == 0) ? (32'h1 << ($urandom % 32)) : '0;
      fwe  = ($urandom % 3 == 0);
      fdat = ($urandom % 5 == 0) ? 8'h8E : 8'h8F;
      rwe  = ($urandom % 97 == 0);
      rdat = 8'($urandom % 2);
    end
    @(negedge clk);
    wset = '0; vset = '0; fwe = 1'b0; rwe = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule